// File: doc/BRIEF.md
# Multichannel Sample Stream Regularizer

A time-shared multichannel filter can take in only one new sample every fixed number of clocks. This block sits in front of such a filter and re-times its feed. Upstream logic may deliver the samples of all channels in a cluster: one per clock, back to back, then a run of idle clocks. The block queues these samples. It then hands them on one at a time, in evenly spaced slots, so the filter never needs to report whether it can accept data.

The slot period is a parameter. For a given configuration it equals the processing clock rate divided by the per-channel sample rate, divided again by the number of channels. For example, with a 320 MHz clock, 10 Msps per channel and 4 channels, the period is 8 clocks. Each issued sample carries a channel index, which is its arrival position within the burst. The block also honours a ready input from the filter: a slot in which ready is low is skipped. Two sticky flags are provided. One reports samples dropped because the queue was full. The other reports input channel tags that arrived out of sequence.

Top module: `stream_pacer`

## Requirements
- R1: During and directly after a synchronous active-high reset, out_valid, overflow_err and order_err are all 0.
- R2: Every accepted sample appears on out_data exactly once, with its value unchanged, and samples leave in the order they arrived.
- R3: out_chan is the sample's arrival index modulo NUM_CH, where the arrival index counts every in_valid cycle since reset starting from 0. In a well-formed burst the channels therefore come out as 0, 1, ..., NUM_CH-1.
- R4: Two out_valid pulses are never closer than SPACING clocks apart. While samples stay queued and out_ready stays high, consecutive pulses are exactly SPACING clocks apart.
- R5: A burst of NUM_CH samples on back-to-back clocks, arriving at an empty queue, is accepted in full and does not set overflow_err.
- R6: out_valid is asserted only in the clock after an edge at which out_ready was sampled high. While out_ready is held low, no sample is issued and nothing queued is lost.
- R7: When in_valid arrives while DEPTH samples are already queued, that sample is dropped and never issued, and overflow_err is set and stays at 1 until reset.
- R8: When in_valid arrives with in_chan different from the expected arrival index modulo NUM_CH, order_err is set and stays at 1 until reset. The sample is still queued and is tagged with its arrival index.
- R9: Reset empties the queue, restarts the arrival index at 0 and clears both error flags. Samples queued before the reset are never issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processing clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | DATA_W | Input sample value |
| in_chan | input | CH_W | Channel tag supplied by the source, checked for sequence |
| out_ready | input | 1 | Downstream can accept a sample in this slot |
| out_valid | output | 1 | Issued sample strobe, at most one per SPACING clocks |
| out_data | output | DATA_W | Issued sample value |
| out_chan | output | CH_W | Channel index of the issued sample |
| overflow_err | output | 1 | Sticky flag: a sample was dropped because the queue was full |
| order_err | output | 1 | Sticky flag: an input channel tag was out of sequence |

## Verification
The assertions take for granted that rst is held high for at least one clock before any checked behaviour begins. They also assume that out_ready and the input strobes are sampled only at rising edges. The bench meets both conditions by driving every input one time unit after a rising edge and by pulsing reset over whole cycles. Overflow and ordering faults are created on purpose, in directed phases: a burst is longer than DEPTH while ready is held low, or a single tag is skipped. In every other phase the bench keeps the input rate within the output rate so that the queue drains between phases.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
   // Width of an index able to hold values 0 .. n-1, never less than 1 bit.
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   // Width of a counter able to hold values 0 .. n.
   function automatic int cnt_width(input int n);
      return $clog2(n + 1);
   endfunction
endpackage

// File: rtl/pacer_fifo.sv
module pacer_fifo #(
   parameter int WIDTH = 18,
   parameter int DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   input  logic             rd_en,
   output logic [WIDTH-1:0] rd_data,
   output logic             empty,
   output logic             full
);
   localparam int PW = pacer_pkg::idx_width(DEPTH);
   localparam int CW = pacer_pkg::cnt_width(DEPTH);
   localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    count;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
         case ({wr_en, rd_en})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/pacer_slot_timer.sv
module pacer_slot_timer #(
   parameter int SPACING = 8
) (
   input  logic clk,
   input  logic rst,
   output logic slot_open
);
   generate
      if (SPACING == 1) begin : g_every_clock
         assign slot_open = 1'b1;
      end else begin : g_counter
         localparam int SW = pacer_pkg::idx_width(SPACING);
         localparam logic [SW-1:0] WRAP = SW'(SPACING - 1);
         logic [SW-1:0] slot_q;

         always_ff @(posedge clk) begin
            if (rst)                 slot_q <= '0;
            else if (slot_q == WRAP) slot_q <= '0;
            else                     slot_q <= slot_q + 1'b1;
         end

         assign slot_open = (slot_q == '0);
      end
   endgenerate
endmodule

// File: rtl/pacer_tagger.sv
module pacer_tagger #(
   parameter int NUM_CH = 4,
   parameter int CH_W   = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            in_valid,
   input  logic [CH_W-1:0] in_chan,
   output logic [CH_W-1:0] arr_tag,
   output logic            order_err
);
   localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);
   logic [CH_W-1:0] arr_q;

   assign arr_tag = arr_q;

   generate
      if (NUM_CH == 1) begin : g_single
         always_ff @(posedge clk) arr_q <= '0;
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (rst)                         arr_q <= '0;
            else if (in_valid && arr_q == LAST_CH) arr_q <= '0;
            else if (in_valid)               arr_q <= arr_q + 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)                                order_err <= 1'b0;
      else if (in_valid && in_chan != arr_q)  order_err <= 1'b1;
   end
endmodule

// File: rtl/stream_pacer.sv
module stream_pacer #(
   parameter int DATA_W  = 16,
   parameter int NUM_CH  = 4,
   parameter int SPACING = 8,
   parameter int DEPTH   = 8,
   localparam int CH_W   = pacer_pkg::idx_width(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [CH_W-1:0]   in_chan,
   input  logic              out_ready,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [CH_W-1:0]   out_chan,
   output logic              overflow_err,
   output logic              order_err
);
   localparam int ENT_W = DATA_W + CH_W;

   generate
      if (SPACING < 1)     begin : g_bad_spacing $error("SPACING must be at least 1"); end
      if (NUM_CH < 1)      begin : g_bad_ch      $error("NUM_CH must be at least 1"); end
      if (DEPTH < NUM_CH)  begin : g_bad_depth   $error("DEPTH must hold a full burst"); end
      if (DATA_W < 1)      begin : g_bad_width   $error("DATA_W must be at least 1"); end
   endgenerate

   logic             slot_open;
   logic             fifo_empty, fifo_full;
   logic             wr_en, issue;
   logic [CH_W-1:0]  arr_tag;
   logic [ENT_W-1:0] rd_entry;

   pacer_tagger #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_tagger (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_chan(in_chan),
      .arr_tag(arr_tag), .order_err(order_err)
   );

   pacer_slot_timer #(.SPACING(SPACING)) u_slot (
      .clk(clk), .rst(rst), .slot_open(slot_open)
   );

   assign wr_en = in_valid && !fifo_full;
   assign issue = slot_open && !fifo_empty && out_ready;

   pacer_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst),
      .wr_en(wr_en), .wr_data({arr_tag, in_data}),
      .rd_en(issue), .rd_data(rd_entry),
      .empty(fifo_empty), .full(fifo_full)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_chan  <= '0;
      end else begin
         out_valid <= issue;
         if (issue) begin
            out_data <= rd_entry[DATA_W-1:0];
            out_chan <= rd_entry[ENT_W-1:DATA_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst)                        overflow_err <= 1'b0;
      else if (in_valid && fifo_full) overflow_err <= 1'b1;
   end
endmodule

// File: rtl/pacer_checker.sv
module pacer_checker #(
   parameter int SPACING = 8
) (
   input logic clk,
   input logic rst,
   input logic in_valid,
   input logic out_ready,
   input logic out_valid,
   input logic overflow_err,
   input logic order_err,
   input logic fifo_full
);
   localparam int GW = pacer_pkg::cnt_width(SPACING);
   logic [GW-1:0] gap_cnt;

   always_ff @(posedge clk) begin
      if (rst)                         gap_cnt <= GW'(SPACING);
      else if (out_valid)              gap_cnt <= GW'(1);
      else if (gap_cnt < GW'(SPACING)) gap_cnt <= gap_cnt + 1'b1;
   end

   assert_reset_quiet_R1: assert property (@(posedge clk)
      rst |=> (!out_valid && !overflow_err && !order_err));

   assert_min_spacing_R4: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (gap_cnt >= GW'(SPACING)));

   assert_ready_gate_R6: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(out_ready));

   assert_overflow_set_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && fifo_full) |=> overflow_err);

   assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      overflow_err |=> overflow_err);

   assert_order_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      order_err |=> order_err);
endmodule

bind stream_pacer pacer_checker #(.SPACING(SPACING)) u_pacer_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
   .out_valid(out_valid), .overflow_err(overflow_err),
   .order_err(order_err), .fifo_full(fifo_full)
);

// File: tb/stream_pacer_tb.sv
module stream_pacer_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W  = 16;
   localparam int NUM_CH  = 4;
   localparam int SPACING = 8;
   localparam int DEPTH   = 8;
   localparam int CH_W    = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [DATA_W-1:0] in_data = '0;
   logic [CH_W-1:0]   in_chan = '0;
   logic out_ready = 1'b1;
   logic out_valid;
   logic [DATA_W-1:0] out_data;
   logic [CH_W-1:0]   out_chan;
   logic overflow_err, order_err;

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int exp_arr = 0;
   int last_out = -1000;
   bit prev_ready = 1'b0;
   logic [DATA_W+CH_W-1:0] sb_q[$];
   int out_times[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc++;

   stream_pacer #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .SPACING(SPACING), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_chan(in_chan),
      .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
      .out_chan(out_chan), .overflow_err(overflow_err), .order_err(order_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // Monitor: compares issued samples against the scoreboard queue.
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         logic [DATA_W+CH_W-1:0] e;
         check(prev_ready, "R6 issue without ready", 1, 0);
         check(cyc - last_out >= SPACING, "R4 spacing", cyc - last_out, SPACING);
         last_out = cyc;
         out_times.push_back(cyc);
         if (sb_q.size() == 0) begin
            check(1'b0, "R2 unexpected sample", int'(out_data), -1);
         end else begin
            e = sb_q.pop_front();
            check(out_data == e[DATA_W-1:0], "R2 data", int'(out_data), int'(e[DATA_W-1:0]));
            check(out_chan == e[DATA_W+CH_W-1:DATA_W], "R3 chan",
                  int'(out_chan), int'(e[DATA_W+CH_W-1:DATA_W]));
         end
      end
      prev_ready = out_ready;
   end

   // Driver: one sample per call, pushes the expected item unless it is to be dropped.
   task automatic send(input logic [DATA_W-1:0] d, input bit keep, input bit bad_tag = 1'b0);
      logic [CH_W-1:0] tag;
      @(posedge clk); #1;
      tag = CH_W'(exp_arr % NUM_CH);
      in_valid = 1'b1;
      in_data  = d;
      in_chan  = bad_tag ? tag + 1'b1 : tag;
      if (keep) sb_q.push_back({tag, d});
      exp_arr++;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(posedge clk); #1;
         in_valid = 1'b0;
      end
   endtask

   task automatic set_ready(input bit r);
      @(posedge clk); #1;
      in_valid  = 1'b0;
      out_ready = r;
   endtask

   task automatic drain(input string req);
      int t = 0;
      while (sb_q.size() != 0 && t < 400) begin
         @(posedge clk); #1; in_valid = 1'b0; t++;
      end
      idle(2 * SPACING);
      check(sb_q.size() == 0, req, sb_q.size(), 0);
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      in_valid = 1'b0;
      rst = 1'b1;
      sb_q.delete();
      exp_arr = 0;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
      check(overflow_err == 1'b0, "R1 overflow_err", overflow_err, 0);
      check(order_err == 1'b0, "R1 order_err", order_err, 0);

      // R2/R3/R4/R5: one back-to-back burst with ready high
      out_times.delete();
      for (int i = 0; i < NUM_CH; i++) send(16'h1000 + 16'(i), 1'b1);
      idle(1);
      drain("R2 burst drained");
      check(out_times.size() == NUM_CH, "R2 burst count", out_times.size(), NUM_CH);
      if (out_times.size() == NUM_CH)
         check(out_times[NUM_CH-1] - out_times[0] == (NUM_CH - 1) * SPACING,
               "R4 exact spacing", out_times[NUM_CH-1] - out_times[0], (NUM_CH - 1) * SPACING);
      check(overflow_err == 1'b0, "R5 no overflow on burst", overflow_err, 0);

      // R2/R3: repeated 1100-style clusters over several frames
      for (int b = 0; b < 6; b++) begin
         send(16'h2000 + 16'(2*b), 1'b1);
         send(16'h2001 + 16'(2*b), 1'b1);
         idle(3 * SPACING);
      end
      drain("R2 pair clusters drained");
      check(overflow_err == 1'b0 && order_err == 1'b0, "R5 clean clusters",
            {overflow_err, order_err}, 0);

      // R6: ready held low blocks issue, nothing lost
      set_ready(1'b0);
      for (int i = 0; i < NUM_CH; i++) send(16'h3000 + 16'(i), 1'b1);
      idle(5 * SPACING);
      check(sb_q.size() == NUM_CH, "R6 held while not ready", sb_q.size(), NUM_CH);
      set_ready(1'b1);
      drain("R6 released");

      // R7: overflow drops the extra sample and sets a sticky flag
      set_ready(1'b0);
      for (int i = 0; i < DEPTH; i++) send(16'h4000 + 16'(i), 1'b1);
      send(16'h4EEE, 1'b0);
      idle(2);
      @(negedge clk);
      check(overflow_err == 1'b1, "R7 overflow set", overflow_err, 1);
      set_ready(1'b1);
      drain("R7 only kept samples issued");
      check(overflow_err == 1'b1, "R7 overflow sticky", overflow_err, 1);

      // R8: out-of-sequence tag flagged, sample kept with arrival tag
      send(16'h5000, 1'b1, 1'b1);
      idle(2);
      @(negedge clk);
      check(order_err == 1'b1, "R8 order_err set", order_err, 1);
      drain("R8 sample still issued");
      check(order_err == 1'b1, "R8 order_err sticky", order_err, 1);

      // R9: reset discards queued samples and clears flags
      set_ready(1'b0);
      for (int i = 0; i < 3; i++) send(16'h6000 + 16'(i), 1'b0);
      idle(1);
      do_reset();
      @(negedge clk);
      check(overflow_err == 1'b0 && order_err == 1'b0, "R9 flags cleared",
            {overflow_err, order_err}, 0);
      set_ready(1'b1);
      idle(4 * SPACING);
      check(last_out < cyc - 3 * SPACING, "R9 stale samples not issued", last_out, 0);
      for (int i = 0; i < NUM_CH; i++) send(16'h7000 + 16'(i), 1'b1);
      idle(1);
      drain("R9 fresh burst after reset");
      check(order_err == 1'b0, "R9 arrival index restarted", order_err, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule